// File: doc/BRIEF.md
# Vector-Ordered Interrupt Controller

The controller watches a bank of interrupt request lines. A request sets a sticky pending flag for its source. Each source also has an enable bit, and the whole enable mask is written through a control-register write port that sits in the I/O space. A global interrupt enable (GIE) flag belongs to the status register, lives in this block and goes out as a port.

When GIE is set and some pending source is also enabled, the controller picks the source with the lowest index. That source has the lowest vector address and therefore the highest priority. The controller offers the winner's vector address to the program counter unit on a valid/ready channel. Once `take_valid` rises, the offer is committed: `take_vec` holds its value until `take_ready` is seen high on a clock edge. The program counter unit may hold `take_ready` low for as long as it likes.

On the handshake edge the controller does two things together: it clears the winner's pending flag and it clears GIE. A return-from-interrupt strobe sets GIE again, and so does a software write to the status bit.

Top module: `vic_top`

## Requirements
- R1: After reset, all pending flags are clear, the enable mask is all zeros, GIE is 0 and `take_valid` is 0.
- R2: A high `irq_req[i]` at a clock edge sets pending flag i. The flag stays set, whatever GIE and the enables hold, until that source is accepted.
- R3: A clock edge with `en_wr` high loads `en_wdata` into the enable mask. Bit i of the mask enables source i.
- R4: `take_valid` rises only on the edge after a cycle in which GIE was 1 and at least one source was both pending and enabled.
- R5: The offered source is the lowest-index source that is both pending and enabled in the cycle before `take_valid` rises.
- R6: `take_vec` equals `VEC_BASE + 2*i` for offered source i.
- R7: While `take_valid` is high and `take_ready` is low, `take_valid` stays high and `take_vec` stays unchanged on the next cycle.
- R8: On a clock edge with `take_valid` and `take_ready` both high, the winner's pending flag clears, GIE becomes 0 and `take_valid` drops. Other pending flags are kept. A new request on that same edge re-sets its flag.
- R9: If no handshake occurs on a clock edge, a high `rti` sets GIE. Otherwise a high `gie_wr` loads `gie_wdata` into GIE. A handshake on the same edge overrides both.
- R10: A source that is pending but disabled is never offered. It keeps its flag, and it is offered once it is enabled while GIE is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Request lines, one per source |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | N_SRC | New enable mask |
| gie_wr | input | 1 | Write strobe for the GIE status bit |
| gie_wdata | input | 1 | New GIE value |
| rti | input | 1 | Return-from-interrupt strobe |
| take_valid | output | 1 | Vector offer valid |
| take_ready | input | 1 | Program counter unit accepts the vector |
| take_vec | output | ADDR_W | Vector address of the offered source |
| gie | output | 1 | Current global interrupt enable |

## Verification
The assertions assume that reset is applied before any traffic and that every input is synchronous to `clk`. They make no assumption about how long `take_ready` stays low or how strobes overlap. The stimulus respects these limits: all inputs change only at the falling edge. The random mix is otherwise unconstrained: requests, enable writes, status writes, `rti` and `take_ready` are drawn freely and may collide on the same edge, so a handshake together with `rti` or with a new request on the winner's line occurs naturally. Directed phases first place each ordering corner on its own.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic {
    OFR_IDLE = 1'b0,
    OFR_HOLD = 1'b1
  } offer_st_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] ack,
  output logic [N_SRC-1:0] pend
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend[g] <= 1'b0;
      else if (req[g])  pend[g] <= 1'b1;
      else if (ack[g])  pend[g] <= 1'b0;
    end

    // The clear path and the set path are separate inputs.
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !req[g]) |=> !pend[g]);
    assert_req_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !ack[g]) |=> pend[g]);
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_SRC-1:0] grant;

  for (genvar g = 0; g < N_SRC; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant[g] = cand[g];
    end else begin : g_rest
      assign grant[g] = cand[g] && !(|cand[g-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

  assign any = |cand;

  always_comb begin
    assert_grant_onehot_R5: assert ($onehot0(grant));
    assert_grant_matches_any_R5: assert ((|grant) == any);
  end
endmodule

// File: rtl/vic_gie.sv
module vic_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic rti,
  input  logic wr,
  input  logic wd,
  output logic gie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie <= 1'b0;
    else if (accept) gie <= 1'b0;
    else if (rti)    gie <= 1'b1;
    else if (wr)     gie <= wd;
  end

  assert_accept_clears_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie);
  assert_rti_sets_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !accept) |=> gie);
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int          N_SRC    = 8,
  parameter int          ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              en_wr,
  input  logic [N_SRC-1:0]  en_wdata,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic              rti,
  output logic              take_valid,
  input  logic              take_ready,
  output logic [ADDR_W-1:0] take_vec,
  output logic              gie
);
  import vic_pkg::*;

  localparam int IDX_W = idx_width(N_SRC);

  logic [N_SRC-1:0] en_q, pend, ack, cand;
  logic [IDX_W-1:0] win_d, win_q;
  logic             any_cand, hs;
  offer_st_e        st_q;

  assign hs   = (st_q == OFR_HOLD) && take_ready;
  assign cand = pend & en_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign ack[g] = hs && (win_q == IDX_W'(g));
  end

  vic_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .ack(ack), .pend(pend)
  );

  vic_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .cand(cand), .any(any_cand), .idx(win_d)
  );

  vic_gie u_gie (
    .clk(clk), .rst_n(rst_n), .accept(hs), .rti(rti),
    .wr(gie_wr), .wd(gie_wdata), .gie(gie)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OFR_IDLE;
      win_q <= '0;
    end else begin
      case (st_q)
        OFR_IDLE: if (gie && any_cand) begin
          st_q  <= OFR_HOLD;
          win_q <= win_d;
        end
        OFR_HOLD: if (take_ready) st_q <= OFR_IDLE;
        default:  st_q <= OFR_IDLE;
      endcase
    end
  end

  assign take_valid = (st_q == OFR_HOLD);
  assign take_vec   = ADDR_W'(VEC_BASE) + ADDR_W'({win_q, 1'b0});

  assert_offer_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(gie));
  assert_offer_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(cand[win_d]));
  assert_vec_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_vec)));
  assert_drop_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !take_valid);
endmodule

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int          N_SRC    = 8;
  localparam int          ADDR_W   = 16;
  localparam int unsigned VEC_BASE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0]  irq_req = '0, en_wdata = '0;
  logic              en_wr = 1'b0, gie_wr = 1'b0, gie_wdata = 1'b0, rti = 1'b0;
  logic              take_ready = 1'b0;
  logic              take_valid, gie;
  logic [ADDR_W-1:0] take_vec;

  always #10 clk = ~clk;

  vic_top #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vic_top (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .rti(rti), .take_valid(take_valid),
    .take_ready(take_ready), .take_vec(take_vec), .gie(gie)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  logic [N_SRC-1:0] m_pend = '0, m_en = '0;
  logic m_gie = 1'b0, m_val = 1'b0;
  int   m_win = 0;

  function automatic int lowest(input logic [N_SRC-1:0] v);
    for (int i = N_SRC-1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = -1;
  endfunction

  function automatic logic [ADDR_W-1:0] vec_of(input int i);
    return ADDR_W'(VEC_BASE + 2*i);
  endfunction

  task automatic cmp(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp({tag, " valid"}, 32'(take_valid), 32'(m_val));
    cmp({tag, " gie R9"}, 32'(gie), 32'(m_gie));
    if (m_val) cmp({tag, " vec R6"}, 32'(take_vec), 32'(vec_of(m_win)));
  endtask

  // Applies inputs for one cycle, advances the model, compares at the next falling edge.
  task automatic step(input logic [N_SRC-1:0] rq, input logic ew, input logic [N_SRC-1:0] ed,
                      input logic gw, input logic gd, input logic rt, input logic rdy);
    logic hs;
    int   c;
    irq_req = rq; en_wr = ew; en_wdata = ed; gie_wr = gw; gie_wdata = gd;
    rti = rt; take_ready = rdy;
    hs = m_val && rdy;
    c  = lowest(m_pend & m_en);
    if (hs) m_pend[m_win] = 1'b0;
    m_pend = m_pend | rq;
    if (ew) m_en = ed;
    if (m_val) begin
      if (rdy) m_val = 1'b0;
    end else if (m_gie && c >= 0) begin
      m_val = 1'b1; m_win = c;
    end
    if (hs) m_gie = 1'b0;
    else if (rt) m_gie = 1'b1;
    else if (gw) m_gie = gd;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step('0, 0, '0, 0, 0, 0, rdy);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    tag = "R1";
    check_outputs();
    rst_n = 1'b1;
    idle(2, 1'b0);

    tag = "R2 R4";   // request held pending while GIE clear
    step(8'h10, 0, '0, 0, 0, 0, 0);
    idle(3, 1'b0);
    tag = "R3 R10";  // enable the source later, still no GIE
    step('0, 1, 8'h10, 0, 0, 0, 0);
    idle(2, 1'b0);
    tag = "R4 R9";   // GIE write starts the offer
    step('0, 0, '0, 1, 1, 0, 0);
    idle(2, 1'b0);
    tag = "R7";      // held without ready
    idle(3, 1'b0);
    tag = "R8";
    step('0, 0, '0, 0, 0, 0, 1);
    idle(2, 1'b0);

    tag = "R5 R6";   // three sources, lowest enabled wins
    step(8'h8A, 1, 8'h8A, 0, 0, 0, 0);
    step('0, 0, '0, 0, 0, 1, 0);
    idle(2, 1'b0);
    step('0, 0, '0, 0, 0, 0, 1);
    tag = "R9 R8";   // rti and handshake together: handshake wins
    step('0, 0, '0, 0, 0, 1, 0);
    idle(1, 1'b0);
    step('0, 0, '0, 0, 0, 1, 1);
    step('0, 0, '0, 0, 0, 1, 0);
    idle(3, 1'b1);
    tag = "R10";     // disabled source stays pending until enabled
    step(8'h01, 1, 8'h00, 1, 1, 0, 0);
    idle(3, 1'b1);
    step('0, 1, 8'h01, 0, 0, 0, 0);
    idle(3, 1'b1);

    tag = "R2 R5 R7 R8 R9 random";
    for (int k = 0; k < 4000; k++) begin
      logic [N_SRC-1:0] rq;
      rq = (($urandom % 4) == 0) ? N_SRC'($urandom) & N_SRC'($urandom) : '0;
      step(rq, ($urandom % 16) == 0, N_SRC'($urandom), ($urandom % 20) == 0,
           1'($urandom), ($urandom % 6) == 0, 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule